// File: doc/BRIEF.md
# Serial Character Transmitter with Line Break

This block serializes 8-bit characters onto a single transmit line. Characters are written into a 16-entry queue through a valid/ready port. A framing engine removes them from the queue one at a time and sends each as a frame: one low start bit, the data bits with the least significant bit first, an optional parity bit, and one high stop bit. Each bit is held for 16 pulses of an oversampling tick supplied from outside, so the baud rate is set by whoever drives that tick.

Three plain control inputs set the line behaviour. Two of them choose whether a parity bit is present and whether that bit gives even or odd parity. The third asks for a line break. A break never cuts a frame short. The line goes low only after the current stop bit has finished, and it stays low while the request is held. The queue is neither drained nor cleared during a break. When the request is dropped, the line is held high for one full bit time, and then the queued characters are sent in order. A valid break needs the request held for at least one frame time. In normal use the request is 0.

Write port rules: a character is taken on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low exactly when the queue holds 16 characters. A writer that presents data while `wr_ready` is low is not served, and that character is not stored. The writer may hold `wr_valid` and `wr_data` until `wr_ready` returns.

Top module: `serial_tx_brk`

## Requirements
- R1: After reset, `txd` is 1, `busy` is 0 and `wr_ready` is 1. While no frame, break or recovery interval is under way, `txd` stays 1.
- R2: A frame is a start bit of 0, then the 8 data bits with bit 0 first, then a stop bit of 1. Every bit lasts exactly 16 `baud_tick` pulses.
- R3: With `par_en` at 0 the stop bit comes directly after data bit 7. With `par_en` at 1 a single parity bit is placed between data bit 7 and the stop bit.
- R4: With `par_even` at 1 the parity bit makes the number of ones across the data and parity bits even. With `par_even` at 0 it makes that number odd.
- R5: `par_en` and `par_even` are captured when a frame begins. Changing them while the frame is on the line does not alter that frame.
- R6: When `brk_req` is raised during a frame, the frame finishes intact with its stop bit, and `txd` is then driven 0 for as long as `brk_req` stays 1. When `brk_req` is raised while the line is idle, the break starts at once.
- R7: No character leaves the queue while a break is active. The queued characters survive the break and are sent after it.
- R8: When `brk_req` falls, `txd` returns to 1 and stays at 1 for at least 16 `baud_tick` pulses before any start bit is sent.
- R9: The queue holds 16 characters. When it is full, `wr_ready` is 0 and an offered character is not stored and is never transmitted.
- R10: Characters are transmitted in the order they were accepted.
- R11: `busy` is 1 while a frame, a break or the recovery interval is under way, or while the queue is not empty. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| wr_valid | input | 1 | A character is offered on `wr_data` |
| wr_ready | output | 1 | The queue can accept a character |
| wr_data | input | 8 | Character to queue |
| par_en | input | 1 | Insert a parity bit |
| par_even | input | 1 | 1 selects even parity, 0 selects odd parity |
| brk_req | input | 1 | Hold the line low after the current frame |
| txd | output | 1 | Serial output, high when idle |
| busy | output | 1 | Transmitter or queue is active |

## Verification
All 256 character values are sent, and the three line modes (no parity, odd parity, even parity) rotate across the sweep. This shows the bit order and both parity polarities for every data pattern. It also shows that a missing parity slot is really missing: a stray bit would land where the stop bit is sampled. A character of all ones, sent with the tick running every third clock, isolates the exact width of the start bit. A frame whose line settings change right after its start bit shows whether the settings were captured at the start of the frame. A break raised in the middle of a frame, held over a write sequence that overfills the queue and then released, tells apart four things: a frame cut short, a queue drained during the break, a recovery gap that is too short, and an overflow write that gets stored.

// File: rtl/stx_pkg.sv
package stx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4,
    ST_BRK   = 3'd5,
    ST_GUARD = 3'd6
  } stx_state_e;

  typedef struct packed {
    logic par_en;
    logic par_even;
  } line_cfg_t;

endpackage

// File: rtl/stx_fifo.sv
module stx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  // DEPTH must be a power of two: the extra pointer bit tells full from empty
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp;
  logic         do_push, do_pop;

  assign empty   = (wp == rp);
  assign full    = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp[AW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp[AW-1:0]] <= wdata;
  end

endmodule

// File: rtl/stx_bit_timer.sv
module stx_bit_timer #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  output logic bit_end
);
  localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;

  logic [CW-1:0] cnt;

  assign bit_end = run && tick && (cnt == CW'(OVS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= bit_end ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/stx_shifter.sv
module stx_shifter
  import stx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              q_empty,
  input  logic [DATA_W-1:0] q_data,
  input  line_cfg_t         cfg,
  input  logic              brk_req,
  output logic              pop,
  output logic              txd,
  output stx_state_e        state,
  output logic              cfg_par_en
);
  localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  stx_state_e        st, st_nx;
  logic [DATA_W-1:0] shreg;
  logic [IW-1:0]     bidx;
  logic              pbit;
  line_cfg_t         cfg_l;
  logic              run, bit_end, launch;

  assign run    = (st != ST_IDLE) && (st != ST_BRK);
  assign launch = (st == ST_IDLE) && !brk_req && tick && !q_empty;
  assign pop    = launch;

  stx_bit_timer #(.OVS(OVS)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .run     (run),
    .bit_end (bit_end)
  );

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE: begin
        if (brk_req)     st_nx = ST_BRK;
        else if (launch) st_nx = ST_START;
      end
      ST_START: if (bit_end) st_nx = ST_DATA;
      ST_DATA: begin
        if (bit_end && bidx == IW'(DATA_W - 1))
          st_nx = cfg_l.par_en ? ST_PAR : ST_STOP;
      end
      ST_PAR:   if (bit_end) st_nx = ST_STOP;
      ST_STOP:  if (bit_end) st_nx = ST_IDLE;
      ST_BRK:   if (!brk_req) st_nx = ST_GUARD;
      ST_GUARD: if (bit_end) st_nx = ST_IDLE;
      default:  st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      shreg <= '0;
      bidx  <= '0;
      pbit  <= 1'b0;
      cfg_l <= '0;
    end else begin
      st <= st_nx;
      if (launch) begin
        shreg <= q_data;
        cfg_l <= cfg;
        pbit  <= cfg.par_even ? ^q_data : ~^q_data;
        bidx  <= '0;
      end else if (st == ST_DATA && bit_end) begin
        shreg <= shreg >> 1;
        bidx  <= bidx + 1'b1;
      end
    end
  end

  always_comb begin
    unique case (st)
      ST_START: txd = 1'b0;
      ST_DATA:  txd = shreg[0];
      ST_PAR:   txd = pbit;
      ST_BRK:   txd = 1'b0;
      default:  txd = 1'b1;
    endcase
  end

  assign state      = st;
  assign cfg_par_en = cfg_l.par_en;

endmodule

// File: rtl/serial_tx_brk.sv
module serial_tx_brk
  import stx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              brk_req,
  output logic              txd,
  output logic              busy
);
  logic [DATA_W-1:0] q_data;
  logic              q_empty, q_full, q_pop;
  stx_state_e        sh_state;
  logic              sh_par_en;
  line_cfg_t         cfg;

  assign cfg.par_en   = par_en;
  assign cfg.par_even = par_even;

  stx_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_queue (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (wr_valid),
    .wdata (wr_data),
    .pop   (q_pop),
    .rdata (q_data),
    .empty (q_empty),
    .full  (q_full)
  );

  stx_shifter #(.DATA_W(DATA_W), .OVS(OVS)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (baud_tick),
    .q_empty    (q_empty),
    .q_data     (q_data),
    .cfg        (cfg),
    .brk_req    (brk_req),
    .pop        (q_pop),
    .txd        (txd),
    .state      (sh_state),
    .cfg_par_en (sh_par_en)
  );

  assign wr_ready = !q_full;
  assign busy     = (sh_state != ST_IDLE) || !q_empty;

endmodule

// File: rtl/serial_tx_brk_chk.sv
module serial_tx_brk_chk
  import stx_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       txd,
  input logic       busy,
  input logic       brk_req,
  input logic       q_pop,
  input logic       q_full,
  input stx_state_e sh_state,
  input logic       sh_par_en
);

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sh_state == ST_IDLE |-> txd);

  // R6
  brk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sh_state == ST_BRK |-> !txd);

  // R6
  no_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_state == ST_START || sh_state == ST_DATA || sh_state == ST_PAR) |=> sh_state != ST_BRK);

  // R7
  brk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sh_state == ST_BRK |-> !q_pop);

  // R5
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sh_state != ST_IDLE |=> $stable(sh_par_en));

  // R8
  guard_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_state == ST_BRK && !brk_req) |=> sh_state == ST_GUARD);

  // R9
  full_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_full && !q_pop) |=> q_full);

  // R11
  quiet_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

endmodule

bind serial_tx_brk serial_tx_brk_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .txd       (txd),
  .busy      (busy),
  .brk_req   (brk_req),
  .q_pop     (q_pop),
  .q_full    (q_full),
  .sh_state  (sh_state),
  .sh_par_en (sh_par_en)
);

// File: tb/serial_tx_brk_test.sv
module serial_tx_brk_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, baud_tick, wr_valid, par_en, par_even, brk_req;
  logic [7:0] wr_data;
  logic       wr_ready, txd, busy;
  int         div = 1;
  int         n_run = 0;
  int         n_fail = 0;

  serial_tx_brk uut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .par_en(par_en), .par_even(par_even), .brk_req(brk_req),
    .txd(txd), .busy(busy)
  );

  initial begin
    int tc;
    tc = 0;
    baud_tick = 1'b0;
    forever begin
      @(negedge clk);
      tc++;
      if (tc >= div) begin
        baud_tick = 1'b1;
        tc = 0;
      end else begin
        baud_tick = 1'b0;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, output bit acc);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    acc      = wr_ready;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_low();
    do @(negedge clk); while (txd !== 1'b0);
  endtask

  task automatic read_rest(input bit hp, output logic [7:0] d, output logic pb,
                           output logic st_ok, output logic sp_ok);
    repeat (8 * div) @(negedge clk);
    st_ok = (txd == 1'b0);
    for (int k = 0; k < 8; k++) begin
      repeat (16 * div) @(negedge clk);
      d[k] = txd;
    end
    pb = 1'b0;
    if (hp) begin
      repeat (16 * div) @(negedge clk);
      pb = txd;
    end
    repeat (16 * div) @(negedge clk);
    sp_ok = (txd == 1'b1);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic pb, st_ok, sp_ok;
    bit acc;
    int cnt, lows;

    rst_n = 1'b0; wr_valid = 1'b0; wr_data = '0;
    par_en = 1'b0; par_even = 1'b0; brk_req = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(txd == 1'b1, "R1 reset txd", int'(txd), 1);
    check(busy == 1'b0, "R1 reset busy", int'(busy), 0);
    check(wr_ready == 1'b1, "R1 reset wr_ready", int'(wr_ready), 1);

    // sweep of every character, modes rotating: 0 none, 1 odd, 2 even
    for (int i = 0; i < 256; i++) begin
      int mode;
      mode = i % 3;
      par_en   = (mode != 0);
      par_even = (mode == 2);
      push(8'(i), acc);
      wait_low();
      if (i == 0) check(busy == 1'b1, "R11 busy in frame", int'(busy), 1);
      read_rest(mode != 0, d, pb, st_ok, sp_ok);
      check(st_ok && d == 8'(i), "R2 data", int'(d), i);
      if (mode == 0) check(sp_ok, "R3 stop follows data", int'(sp_ok), 1);
      else begin
        check(sp_ok, "R3 stop after parity", int'(sp_ok), 1);
        check(pb == ((mode == 2) ? ^8'(i) : ~^8'(i)), "R4 parity", int'(pb),
              int'((mode == 2) ? ^8'(i) : ~^8'(i)));
      end
    end
    repeat (40) @(negedge clk);
    check(busy == 1'b0 && txd == 1'b1, "R11 idle after sweep", int'(busy), 0);

    // start bit width with a slower tick
    div = 3;
    par_en = 1'b0;
    push(8'hFF, acc);
    wait_low();
    cnt = 1;
    forever begin
      @(negedge clk);
      if (txd == 1'b0) cnt++;
      else break;
    end
    check(cnt == 48, "R2 start bit width", cnt, 48);
    repeat (16 * 3 * 10) @(negedge clk);

    // settings change after the frame has begun
    par_en = 1'b1; par_even = 1'b1;
    push(8'h01, acc);
    wait_low();
    par_en = 1'b0; par_even = 1'b0;
    read_rest(1'b1, d, pb, st_ok, sp_ok);
    check(d == 8'h01 && pb == 1'b1, "R5 captured parity", int'(pb), 1);
    check(sp_ok, "R5 stop after kept parity", int'(sp_ok), 1);
    repeat (16 * div) @(negedge clk);

    // break raised mid-frame
    push(8'h5A, acc);
    wait_low();
    brk_req = 1'b1;
    read_rest(1'b0, d, pb, st_ok, sp_ok);
    check(d == 8'h5A && sp_ok, "R6 frame completes", int'(d), 'h5A);
    repeat (16 * div) @(negedge clk);
    check(txd == 1'b0, "R6 line low in break", int'(txd), 0);
    check(busy == 1'b1, "R11 busy in break", int'(busy), 1);

    // fill the queue during break, one more than it holds
    for (int k = 0; k < 17; k++) begin
      push(8'hA0 + 8'(k), acc);
      check(acc == (k < 16), "R9 ready while filling", int'(acc), int'(k < 16));
    end
    repeat (200) @(negedge clk);
    check(txd == 1'b0, "R7 break holds", int'(txd), 0);
    check(wr_ready == 1'b0, "R7 queue not drained", int'(wr_ready), 0);

    // release and measure recovery gap
    brk_req = 1'b0;
    cnt = 0;
    forever begin
      @(negedge clk);
      if (txd == 1'b0) break;
      cnt++;
    end
    check(cnt >= 16 * div, "R8 recovery gap", cnt, 16 * div);
    for (int k = 0; k < 16; k++) begin
      if (k != 0) wait_low();
      read_rest(1'b0, d, pb, st_ok, sp_ok);
      check(st_ok && sp_ok && d == 8'hA0 + 8'(k), "R10 order after break (R7)",
            int'(d), int'(8'hA0 + 8'(k)));
    end
    repeat (20 * div) @(negedge clk);
    check(busy == 1'b0, "R11 idle after drain", int'(busy), 0);
    lows = 0;
    repeat (600) begin
      @(negedge clk);
      if (txd == 1'b0) lows++;
    end
    check(lows == 0, "R9 overflow write not sent", lows, 0);

    summary();
    $finish;
  end

endmodule